// File: doc/BRIEF.md
# Paired-Counter PWM Timer

This block builds one pulse-width-modulated output from two down-counters that work as a pair. The first counter, the period counter, runs as a repeating interval timer. It counts down on each count strobe. When it reaches zero it raises a one-cycle period interrupt and reloads from the period register. The second counter, the width counter, is a one-shot. Each period interrupt restarts it from the duty register. It counts down on the same strobes, then rests at zero. The output is active while the width counter is non-zero.

Software writes the period and duty registers through a small write port at any time. The counters copy these registers only when a period interrupt occurs. A new period and a new duty written on opposite sides of an interrupt therefore produce one cycle with mismatched settings. The output frequency is 1/(period+1) of the strobe rate. The duty ratio is duty/(period+1). Any duty of at least period+1 keeps the output active all the time. All logic runs on a single clock. The strobe is a single-cycle enable that comes from a prescaler outside the block.

Top module: `pwm_pair_timer`

## Requirements
- R1: After reset, period_irq is 0, both data registers are 0, and pwm_out sits at the inactive level, which is the inverse of pol.
- R2: While stopped, a cycle with start high runs the pair from the next clock. period_irq pulses high for exactly that one next cycle, and both counters load from the data registers.
- R3: While running, the period counter moves only on a cycle with cnt_en high. A period interrupt occurs on every (period+1)-th strobe after the previous one and is seen as a one-cycle pulse on period_irq on the following clock.
- R4: In the cycle that period_irq is high, the output becomes active if duty is non-zero. It stays active for exactly duty strobes and is then inactive until the next period interrupt.
- R5: A duty value of 0 keeps pwm_out inactive for the whole time the pair runs.
- R6: A duty value greater than or equal to period+1 keeps pwm_out active for the whole time the pair runs. The value saturates and does not wrap.
- R7: A write to either data register changes the counters only at the next period interrupt. Until then, the current period and width continue unchanged.
- R8: When start is low, the pair stops on the next clock. pwm_out goes inactive, no period interrupt occurs, and a later high start restarts the pair as in R2.
- R9: pol=1 makes the active level logic high. pol=0 makes the active level logic low. pol takes effect on pwm_out at once.
- R10: A cycle with wr_en=1 writes wr_data into the period register when wr_sel=0 and into the duty register when wr_sel=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Single-cycle count strobe from the external prescaler |
| start | input | 1 | Run request; high runs the pair, low stops it |
| wr_en | input | 1 | Data register write strobe |
| wr_sel | input | 1 | Register select: 0 period, 1 duty |
| wr_data | input | W | Write data |
| pol | input | 1 | Active level of the output: 1 high, 0 low |
| period_irq | output | 1 | One-cycle period interrupt pulse |
| pwm_out | output | 1 | PWM output |

## Verification
The bench targets these corner cases:
- **Period of zero.** A design that mishandles the zero compare would either never interrupt or interrupt only every 2^W strobes.
- **Duty of zero and duty of period+1 or more.** An off-by-one design would show a one-strobe glitch. A wrapping compare would give a short pulse where a solid level is expected.
- **Writes placed just before and just after an interrupt.** A design that loads registers directly into the counters would cut a period short or stretch one.
- **Stop and restart in the middle of a period, with uneven gaps between strobes.** This exposes counters that run without the enable, and an output left active after stop.

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         start,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         pol,
  output logic         period_irq,
  output logic         pwm_out
);

  logic [W-1:0] per_q, duty_q, mcnt, scnt;
  logic         run, irq_q;

  wire evt_start = start & ~run;
  wire evt_wrap  = run & start & cnt_en & (mcnt == '0);
  wire evt       = evt_start | evt_wrap;
  wire act       = run & (scnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      duty_q <= '0;
      mcnt   <= '0;
      scnt   <= '0;
      run    <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_sel) duty_q <= wr_data;
        else        per_q  <= wr_data;
      end
      run   <= start;
      irq_q <= evt;
      if (evt) begin
        mcnt <= per_q;
        scnt <= duty_q;
      end else if (!start) begin
        scnt <= '0;
      end else if (cnt_en) begin
        mcnt <= mcnt - 1'b1;
        if (scnt != '0) scnt <= scnt - 1'b1;
      end
    end
  end

  assign period_irq = irq_q;
  assign pwm_out    = pol ? act : ~act;

endmodule

// File: rtl/pwm_pair_timer_chk.sv
module pwm_pair_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         start,
  input logic         pol,
  input logic         period_irq,
  input logic         pwm_out,
  input logic         run,
  input logic [W-1:0] mcnt,
  input logic [W-1:0] scnt
);

  // R8
  stop_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !period_irq);

  // R8
  stop_idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (pwm_out != pol));

  // R2
  start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> period_irq);

  // R3
  period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && start && !cnt_en) |=> $stable(mcnt));

  // R4
  width_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !period_irq) |-> (scnt <= $past(scnt)));

endmodule

bind pwm_pair_timer pwm_pair_timer_chk #(.W(W)) u_chk (.*);

// File: tb/pwm_pair_timer_bench.sv
module pwm_pair_timer_bench;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cnt_en = 0, start = 0, wr_en = 0, wr_sel = 0, pol = 1;
  logic [W-1:0] wr_data = '0;
  logic period_irq, pwm_out;

  int total = 0, bad = 0;
  bit done = 0;

  // reference state
  int m_per = 0, m_duty = 0, m_P = 0, m_D = 0, m_k = 0;
  bit m_run = 0, m_irq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_pair_timer #(.W(W)) u_pwm_pair_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .start(start),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .pol(pol),
    .period_irq(period_irq), .pwm_out(pwm_out));

  function automatic bit exp_pwm();
    bit a = m_run && (m_D > m_k);
    return pol ? a : !a;
  endfunction

  function automatic string pwm_tag();
    if (!m_run) return "R8";
    if (m_D == 0) return "R5";
    if (m_D > m_P) return "R6";
    return "R4";
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!start) begin
      m_run = 0; m_irq = 0;
    end else if (!m_run) begin
      m_run = 1; m_k = 0; m_P = m_per; m_D = m_duty; m_irq = 1;
    end else if (cnt_en) begin
      if (m_k == m_P) begin
        m_k = 0; m_P = m_per; m_D = m_duty; m_irq = 1;
      end else begin
        m_k++; m_irq = 0;
      end
    end else m_irq = 0;
    if (wr_en) begin
      if (wr_sel) m_duty = int'(wr_data);
      else        m_per  = int'(wr_data);
    end
  endtask

  task automatic cyc(bit st, bit en, bit we = 0, bit ws = 0, int wd = 0);
    start = st; cnt_en = en; wr_en = we; wr_sel = ws; wr_data = W'(wd);
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk(m_irq && m_run ? "R3" : "R8", period_irq, m_irq);
    chk(pwm_tag(), pwm_out, exp_pwm());
  endtask

  // R10: program both registers through the write port
  task automatic prog(int p, int d, bit st);
    cyc(st, 0, 1, 0, p);
    cyc(st, 0, 1, 1, d);
  endtask

  task automatic run_n(int n, int pct);
    for (int i = 0; i < n; i++) cyc(1, ($urandom % 100) < pct);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", period_irq, 1'b0);
    chk("R1", pwm_out, 1'b0);
    pol = 0; #1;
    chk("R1", pwm_out, 1'b1);
    pol = 1;
    rst_n = 1;
    @(negedge clk);

    // R2, R4: period 4, duty 2, strobe every cycle
    prog(4, 2, 0);
    cyc(1, 1);
    chk("R2", period_irq, 1'b1);
    run_n(20, 100);

    // R5: duty zero
    prog(3, 0, 1);
    run_n(20, 100);
    // R6: duty equals period+1, then above
    prog(3, 4, 1);
    run_n(20, 100);
    prog(3, 9, 1);
    run_n(20, 70);
    // period zero
    prog(0, 1, 1);
    run_n(10, 100);
    prog(0, 0, 1);
    run_n(10, 100);

    // R7: split write across an interrupt boundary
    prog(5, 3, 1);
    run_n(14, 100);
    cyc(1, 1, 1, 0, 2);
    run_n(6, 100);
    cyc(1, 1, 1, 1, 1);
    run_n(20, 100);

    // R8: stop mid-period, strobes while stopped, restart
    cyc(1, 1); cyc(1, 1);
    for (int i = 0; i < 5; i++) cyc(0, 1);
    run_n(15, 100);

    // R9: polarity flip while running
    pol = 0;
    run_n(15, 100);
    pol = 1;

    // random segments
    for (int s = 0; s < 60; s++) begin
      int p = $urandom % 13;
      int d = $urandom % (p + 4);
      pol = $urandom % 2;
      prog(p, d, ($urandom % 4) != 0);
      for (int i = 0; i < 80; i++) begin
        int r = $urandom % 100;
        if (r < 3) cyc(0, $urandom % 2);
        else if (r < 6) cyc(1, $urandom % 2, 1, $urandom % 2, $urandom % 12);
        else cyc(1, ($urandom % 100) < 60);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule